// File: doc/BRIEF.md
# Dual-Slope Audio PWM Generator

This block turns a stream of 8-bit audio samples into a centre-aligned pulse train. An internal counter ramps up from zero to its top value and back down again, one step per clock with no prescaler. The output is high while the count is at or above the active sample value. The default width of 8 bits gives a period of 510 clocks. An external low-pass filter recovers the audio waveform, and that filter is not part of this block.

Samples come from a data source through a one-word write port into a shadow register. The shadow value moves into the active compare register only as the counter reaches its peak, so a write never splits a half-period. A one-cycle request strobe marks the bottom of each ramp. The source uses it as its cue to supply the next sample, so the sample rate equals the PWM period.

Top module: `pwm_dual_slope_dac`

## Requirements
- R1: While enabled, the count climbs 0,1,…,255 then falls 254,…,1 and returns to 0, so consecutive request strobes are exactly 510 clocks apart.
- R2: `sample_req` is high for exactly one clock per period: the cycle in which the count is 0.
- R3: With a non-zero active value v, `pwm_out` is high in exactly those cycles where the count is at or above v. A period with v unchanged therefore has 511−2v high cycles.
- R4: A value written through `sample_we`/`sample_data` is held in a shadow register and becomes active from the cycle in which the count shows 255. Within a period that starts at count 0, the rising cycles 0..254 use the old value (255−old high cycles, or 0 if old is 0) and the cycles 255..1 use the new value (256−new high cycles, or 0 if new is 0).
- R5: An active value of 0 keeps `pwm_out` low for the whole period.
- R6: An active value of 255 gives one high cycle per period, at the peak count.
- R7: While `en` is low, `pwm_out` and `sample_req` are low and the counter is held at 0. On the first clock after `en` returns high, `sample_req` is asserted and a fresh period begins.
- R8: During and after reset, the shadow and active values are 0, so `pwm_out` and `sample_req` stay low until enabled, and the first enabled period has no high cycles.
- R9: A sample written while `en` is low is kept in the shadow register and is applied at the first peak after the block is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low clears the counter and silences the outputs |
| sample_we | input | 1 | Write strobe for the shadow sample register |
| sample_data | input | 8 | Sample value to place in the shadow register |
| pwm_out | output | 1 | Centre-aligned pulse output |
| sample_req | output | 1 | One-cycle strobe at the bottom of each ramp |

## Verification
The request strobe appears in the first clock after `en` rises. After that, each later strobe follows the previous one by exactly 510 clocks. A sample written in a strobe cycle changes the pulse starting 255 clocks later, at the peak. The bench therefore measures high time over windows that open at one strobe and close at the next. For each window the driver computes the expected width from the old and new sample, split at the peak. It queues that width when it writes, and the monitor pops it when the window closes. The checks for the disabled state and for the first strobe after enable sample at the falling edge that follows the clock edge on which they take effect.

// File: rtl/pwm_dac_pkg.sv
// Shared types for the dual-slope PWM generator.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_dac_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } ramp_dir_e;
endpackage

// File: rtl/pwm_ramp_counter.sv
// Up/down ramp counter: 0 -> MAX -> 1 -> 0, one step per clock.
// Flags the bottom of the ramp and the cycle just before the peak.
// Assumes: en low holds the ramp at 0; the ramp starts one clock after en rises.
module pwm_ramp_counter
    import pwm_dac_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [WIDTH-1:0] cnt_o,
    output logic             run_o,
    output logic             bottom_o,
    output logic             peak_load_o
);
    localparam logic [WIDTH-1:0] TOP     = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] PRE_TOP = TOP - 1'b1;

    logic [WIDTH-1:0] cnt_q;
    ramp_dir_e        dir_q;
    logic             run_q;

    // Advance the ramp, turning around at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (run_q) begin
                if (dir_q == DIR_UP) begin
                    if (cnt_q == TOP) begin
                        dir_q <= DIR_DOWN;
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        dir_q <= DIR_UP;
                        cnt_q <= cnt_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
        end
    end

    // Decode the ramp positions the neighbours act on.
    always_comb begin
        cnt_o       = cnt_q;
        run_o       = run_q;
        bottom_o    = run_q && (cnt_q == '0);
        peak_load_o = en && run_q && (dir_q == DIR_UP) && (cnt_q == PRE_TOP);
    end

    p_turn_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run_q && cnt_q == TOP) |=> (cnt_q == PRE_TOP));
    p_turn_bottom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run_q && cnt_q == '0) |=> (cnt_q == 1));
    p_hold_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (cnt_q == '0 && !run_q));
endmodule

// File: rtl/pwm_sample_latch.sv
// Shadow and active compare registers.
// The shadow register takes each write; the active register copies the shadow on the peak load pulse.
// Assumes: a write and a load in the same cycle give the active register the old shadow value.
module pwm_sample_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             load_i,
    output logic [WIDTH-1:0] active_o
);
    logic [WIDTH-1:0] shadow_q;
    logic [WIDTH-1:0] active_q;

    // Capture samples from the data source.
    always_ff @(posedge clk) begin
        if (!rst_n)    shadow_q <= '0;
        else if (we_i) shadow_q <= wdata_i;
    end

    // Move the shadow value into the active register at the peak.
    always_ff @(posedge clk) begin
        if (!rst_n)      active_q <= '0;
        else if (load_i) active_q <= shadow_q;
    end

    assign active_o = active_q;

    p_load_at_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> $past(load_i));
endmodule

// File: rtl/pwm_compare.sv
// Magnitude compare of the ramp against the active sample; zero means silent.
// Assumes: the ramp and the active value are registered upstream.
module pwm_compare #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cnt_i,
    input  logic [WIDTH-1:0] active_i,
    output logic             hit_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // The output is on while the ramp is at or above a non-zero sample.
    always_comb begin
        hit_o = (active_i != '0) && (cnt_i >= active_i);
    end

    p_zero_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i == '0) |-> !hit_o);
    p_full_at_peak_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i == TOP && hit_o) |-> (cnt_i == TOP));
endmodule

// File: rtl/pwm_dual_slope_dac.sv
// Top level of the dual-slope audio PWM generator.
// Assumes: the source writes at most one sample per request strobe.
module pwm_dual_slope_dac #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sample_we,
    input  logic [WIDTH-1:0] sample_data,
    output logic             pwm_out,
    output logic             sample_req
);
    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] active;
    logic             run;
    logic             bottom;
    logic             peak_load;
    logic             hit;

    pwm_ramp_counter #(.WIDTH(WIDTH)) u_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .cnt_o       (cnt),
        .run_o       (run),
        .bottom_o    (bottom),
        .peak_load_o (peak_load)
    );

    pwm_sample_latch #(.WIDTH(WIDTH)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (sample_we),
        .wdata_i  (sample_data),
        .load_i   (peak_load),
        .active_o (active)
    );

    pwm_compare #(.WIDTH(WIDTH)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt),
        .active_i (active),
        .hit_o    (hit)
    );

    // Gate both outputs with the enable so that disabling silences them at once.
    always_comb begin
        pwm_out    = en && run && hit;
        sample_req = en && bottom;
    end

    p_silent_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!pwm_out && !sample_req));
    p_single_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |=> !sample_req);
endmodule

// File: tb/pwm_dual_slope_dac_tb.sv
module pwm_dual_slope_dac_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 510;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       sample_we = 1'b0;
    logic [7:0] sample_data = '0;
    logic       pwm_out;
    logic       sample_req;

    int checks = 0;
    int fails  = 0;
    int        exp_q[$];
    string     tag_q[$];
    int        prev_val = 0;
    bit        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dual_slope_dac #(.WIDTH(8)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .sample_we   (sample_we),
        .sample_data (sample_data),
        .pwm_out     (pwm_out),
        .sample_req  (sample_req)
    );

    function automatic int rise_part(input int a);
        return (a == 0) ? 0 : 255 - a;
    endfunction
    function automatic int fall_part(input int b);
        return (b == 0) ? 0 : 256 - b;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // Wait for the next request strobe, seen at a falling edge.
    task automatic wait_req();
        do @(negedge clk); while (!sample_req);
    endtask

    // Called at a strobe's falling edge: optionally write, then queue the window's expected width.
    task automatic push_window(input int nv, input bit do_write, input string tag);
        if (do_write) begin
            #1;
            sample_we   = 1'b1;
            sample_data = nv[7:0];
            @(negedge clk);
            #1 sample_we = 1'b0;
        end
        exp_q.push_back(rise_part(prev_val) + fall_part(nv));
        tag_q.push_back(tag);
        prev_val = nv;
    endtask

    task automatic window(input int nv, input bit do_write, input string tag);
        wait_req();
        push_window(nv, do_write, tag);
    endtask

    // Monitor: measures pulse width and period between strobes, pops expected widths.
    bit measuring = 1'b0;
    bit prev_req  = 1'b0;
    int width_cnt = 0;
    int per_cnt   = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            check(!pwm_out && !sample_req, "R8 outputs low in reset", {pwm_out, sample_req}, 0);
            measuring = 1'b0;
        end else if (!en) begin
            check(!pwm_out && !sample_req, "R7 outputs low while disabled", {pwm_out, sample_req}, 0);
            measuring = 1'b0;
        end else if (sample_req) begin
            check(!prev_req, "R2 strobe one cycle wide", 1, 0);
            if (measuring && exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(width_cnt == e, t, width_cnt, e);
                check(per_cnt == PERIOD, "R1 strobe spacing", per_cnt, PERIOD);
            end
            measuring = 1'b1;
            width_cnt = pwm_out ? 1 : 0;
            per_cnt   = 1;
        end else if (measuring) begin
            width_cnt += pwm_out ? 1 : 0;
            per_cnt++;
        end
        prev_req = sample_req;
    end

    // Driver sequence.
    initial begin
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1 en = 1'b1;
        window(0,   1'b0, "R8 first period silent after reset");
        window(100, 1'b1, "R4 split old 0 new 100");
        window(100, 1'b1, "R3 steady 100");
        window(1,   1'b1, "R4 split old 100 new 1");
        window(1,   1'b1, "R3 steady 1");
        window(255, 1'b1, "R4 split old 1 new 255");
        window(255, 1'b1, "R6 steady 255 single high cycle");
        window(0,   1'b1, "R4 split old 255 new 0");
        window(0,   1'b1, "R5 steady 0 silent");
        window(37,  1'b1, "R4 split old 0 new 37");
        window(37,  1'b0, "R4 no write keeps 37");
        wait_req();
        #1 en = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        sample_we   = 1'b1;
        sample_data = 8'd200;
        @(negedge clk);
        #1 sample_we = 1'b0;
        repeat (5) @(negedge clk);
        check(!pwm_out, "R9 shadow write while disabled has no effect", pwm_out, 0);
        #1 en = 1'b1;
        @(negedge clk);
        check(sample_req, "R7 strobe on first clock after enable", sample_req, 1);
        push_window(200, 1'b0, "R9 disabled write applied at first peak");
        window(200, 1'b0, "R3 steady 200");
        wait_req();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all windows closed", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule